// File: doc/BRIEF.md
# Configurable Macrocell Register Cell

This block is a single programmable-logic output cell. It takes a sum-of-products data term and a handful of product-term control lines, and produces one result. Static configuration inputs choose how that result is formed:

- through a D-type storage element,
- through a T-type storage element, or
- straight through as combinational logic.

The same result leaves the cell twice: once toward the routing network as feedback, and once toward an I/O cell.

The storage element's clock is one of three global clocks or a product-term clock, in true or inverted polarity. The cell runs entirely on a fast system clock. Each selected cell clock is sampled, and its active transition becomes an update strobe. Set, reset and the global set/reset override the stored value at once, without waiting for a cell-clock transition. The global set/reset and the power-up load both place the cell's own user value (a parameter, 0 by default) into the register. A one-cycle init pulse models the power-up load.

Top module: `mc_cell`

## Requirements
- R1: After rstN is released, or one cycle after initPulse, the output holds the USER_INIT value (0 by default; 1 on a cell built with USER_INIT=1), provided no set, reset or global set/reset is active.
- R2: With cfgMode=2'b00 (D) and ptCe=1, an active transition of the selected clock loads sumTerm; without such a transition the output holds.
- R3: With cfgMode=2'b01 (T) and ptCe=1, an active transition inverts the stored value when sumTerm=1 and keeps it when sumTerm=0.
- R4: With cfgMode[1]=1 (bypass), the output equals sumTerm in the same cycle; clocks, enable, set and reset have no effect on it.
- R5: cfgClkSel values 0, 1 and 2 pick gclk[0], gclk[1] and gclk[2]; value 3 picks ptClk. Transitions on sources that are not selected cause no update.
- R6: With cfgClkInv=0 the active transition is the rising edge of the selected source; with cfgClkInv=1 it is the falling edge.
- R7: While ptCe=0, clock transitions leave the stored value unchanged.
- R8: ptSet=1 drives the output to 1 immediately, with no clock transition, and the register keeps 1 after release.
- R9: ptReset=1 drives the output to 0 immediately and wins over ptSet.
- R10: gsr=1 drives the output to USER_INIT immediately and wins over both ptSet and ptReset.
- R11: ioOut always carries the same value as fbOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low asynchronous reset; loads USER_INIT |
| initPulse | input | 1 | Synchronous power-up load of USER_INIT |
| gclk | input | NUM_GCLK | Global clock sources |
| ptClk | input | 1 | Product-term clock source |
| ptCe | input | 1 | Product-term clock enable |
| ptSet | input | 1 | Product-term asynchronous set |
| ptReset | input | 1 | Product-term asynchronous reset |
| gsr | input | 1 | Global set/reset to USER_INIT |
| sumTerm | input | 1 | Sum-of-products data term |
| cfgMode | input | 2 | 00 D, 01 T, 1x bypass |
| cfgClkSel | input | SEL_W | Clock source select |
| cfgClkInv | input | 1 | Clock polarity invert |
| fbOut | output | 1 | Result toward the routing network |
| ioOut | output | 1 | Result toward the I/O cell |

## Verification
The hardest state to reach is a polarity or source change that does not itself count as a clock transition. Flipping cfgClkInv while the source sits low looks like a rising edge. The stimulus therefore drops ptCe, changes the configuration, waits two cycles, and only then re-enables. It then drives the source high and checks that nothing is loaded, and drives it low and checks that the load happens. The set and reset overrides are sampled one time unit after they are applied and before any clock edge, which shows that they act without a cell-clock transition.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    MODE_D    = 2'b00,
    MODE_T    = 2'b01,
    MODE_BYP  = 2'b10,
    MODE_BYP2 = 2'b11
  } cellMode_t;

  typedef struct packed {
    logic initHit;
    logic asyncHit;
    logic asyncVal;
    logic capture;
    logic toggle;
    logic bypass;
  } cellStrobe_t;

endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
#(
  parameter int   NUM_GCLK  = 3,
  parameter logic USER_INIT = 1'b0,
  parameter int   SEL_W     = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                initPulse,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                ptClk,
  input  logic                ptCe,
  input  logic                ptSet,
  input  logic                ptReset,
  input  logic                gsr,
  input  logic [1:0]          cfgMode,
  input  logic [SEL_W-1:0]    cfgClkSel,
  input  logic                cfgClkInv,
  output cellStrobe_t         strobe
);

  logic [NUM_GCLK:0] srcVec;
  logic selRaw;
  logic selLvl;
  logic prevLvl;
  logic activeEdge;
  logic regMode;
  logic tMode;

  for (genvar g = 0; g < NUM_GCLK; g++) begin : g_src
    assign srcVec[g] = gclk[g];
  end
  assign srcVec[NUM_GCLK] = ptClk;

  // codes at or above NUM_GCLK pick the product-term clock
  always_comb begin
    selRaw = srcVec[NUM_GCLK];
    for (int i = 0; i < NUM_GCLK; i++) begin
      if (cfgClkSel == SEL_W'(i)) selRaw = srcVec[i];
    end
  end

  assign selLvl = selRaw ^ cfgClkInv;

  // history starts high so no transition is seen right after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b1;
    else       prevLvl <= selLvl;
  end

  assign activeEdge = selLvl & ~prevLvl;

  always_comb begin
    regMode = 1'b1;
    tMode   = 1'b0;
    case (cellMode_t'(cfgMode))
      MODE_D:   begin regMode = 1'b1; tMode = 1'b0; end
      MODE_T:   begin regMode = 1'b1; tMode = 1'b1; end
      default:  begin regMode = 1'b0; tMode = 1'b0; end
    endcase
  end

  always_comb begin
    strobe.initHit  = initPulse;
    strobe.asyncHit = gsr | ptSet | ptReset;
    if (gsr)          strobe.asyncVal = USER_INIT;
    else if (ptReset) strobe.asyncVal = 1'b0;
    else              strobe.asyncVal = 1'b1;
    strobe.capture  = activeEdge & ptCe & regMode;
    strobe.toggle   = tMode;
    strobe.bypass   = ~regMode;
  end

endmodule

// File: rtl/mc_dp.sv
module mc_dp
  import mc_pkg::*;
#(
  parameter logic USER_INIT = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sumTerm,
  input  cellStrobe_t strobe,
  output logic        cellOut
);

  logic stateQ;
  logic loadVal;
  logic heldView;

  assign loadVal = strobe.toggle ? (stateQ ^ sumTerm) : sumTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stateQ <= USER_INIT;
    else if (strobe.initHit)  stateQ <= USER_INIT;
    else if (strobe.asyncHit) stateQ <= strobe.asyncVal;
    else if (strobe.capture)  stateQ <= loadVal;
  end

  // overrides reach the output without waiting for a clock
  assign heldView = strobe.asyncHit ? strobe.asyncVal : stateQ;
  assign cellOut  = strobe.bypass ? sumTerm : heldView;

endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
#(
  parameter int   NUM_GCLK  = 3,
  parameter logic USER_INIT = 1'b0,
  localparam int  SEL_W     = $clog2(NUM_GCLK + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                initPulse,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                ptClk,
  input  logic                ptCe,
  input  logic                ptSet,
  input  logic                ptReset,
  input  logic                gsr,
  input  logic                sumTerm,
  input  logic [1:0]          cfgMode,
  input  logic [SEL_W-1:0]    cfgClkSel,
  input  logic                cfgClkInv,
  output logic                fbOut,
  output logic                ioOut
);

  cellStrobe_t strobe;
  logic cellOut;

  mc_ctrl #(.NUM_GCLK(NUM_GCLK), .USER_INIT(USER_INIT), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .gclk(gclk), .ptClk(ptClk),
    .ptCe(ptCe), .ptSet(ptSet), .ptReset(ptReset), .gsr(gsr),
    .cfgMode(cfgMode), .cfgClkSel(cfgClkSel), .cfgClkInv(cfgClkInv),
    .strobe(strobe)
  );

  mc_dp #(.USER_INIT(USER_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .sumTerm(sumTerm), .strobe(strobe), .cellOut(cellOut)
  );

  assign fbOut = cellOut;
  assign ioOut = cellOut;

endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk #(
  parameter logic USER_INIT = 1'b0
) (
  input logic       clk,
  input logic       rstN,
  input logic       initPulse,
  input logic       ptCe,
  input logic       ptSet,
  input logic       ptReset,
  input logic       gsr,
  input logic       sumTerm,
  input logic [1:0] cfgMode,
  input logic       fbOut
);

  logic anyForce;
  assign anyForce = gsr | ptSet | ptReset;

  // R1
  init_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (initPulse && !anyForce) |=> (cfgMode[1] || anyForce || fbOut == USER_INIT));

  // R4
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode[1] |-> fbOut == sumTerm);

  // R7
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMode[1] && !anyForce && $past(!ptCe && !initPulse && !anyForce && !cfgMode[1]))
      |-> $stable(fbOut));

  // R8
  set_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ptSet && !ptReset && !gsr && !cfgMode[1]) |-> fbOut);

  // R9
  reset_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ptReset && !gsr && !cfgMode[1]) |-> !fbOut);

  // R10
  gsr_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gsr && !cfgMode[1]) |-> fbOut == USER_INIT);

endmodule

bind mc_cell mc_cell_chk #(.USER_INIT(USER_INIT)) u_chk (
  .clk(clk), .rstN(rstN), .initPulse(initPulse), .ptCe(ptCe), .ptSet(ptSet),
  .ptReset(ptReset), .gsr(gsr), .sumTerm(sumTerm), .cfgMode(cfgMode), .fbOut(fbOut)
);

// File: tb/mc_cell_tb.sv
module mc_cell_tb;

  logic clk = 1'b0;
  logic rstN, initPulse, ptClk, ptCe, ptSet, ptReset, gsr, sumTerm, cfgClkInv;
  logic [2:0] gclk;
  logic [1:0] cfgMode, cfgClkSel;
  logic fbOut, ioOut, fbOutHi, ioOutHi;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mc_cell u_dut (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .gclk(gclk), .ptClk(ptClk),
    .ptCe(ptCe), .ptSet(ptSet), .ptReset(ptReset), .gsr(gsr), .sumTerm(sumTerm),
    .cfgMode(cfgMode), .cfgClkSel(cfgClkSel), .cfgClkInv(cfgClkInv),
    .fbOut(fbOut), .ioOut(ioOut)
  );

  mc_cell #(.USER_INIT(1'b1)) u_dutHi (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .gclk(gclk), .ptClk(ptClk),
    .ptCe(ptCe), .ptSet(ptSet), .ptReset(ptReset), .gsr(gsr), .sumTerm(sumTerm),
    .cfgMode(cfgMode), .cfgClkSel(cfgClkSel), .cfgClkInv(cfgClkInv),
    .fbOut(fbOutHi), .ioOut(ioOutHi)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // source index 0..2 global, 3 product-term; level driven at a negedge
  task automatic setSrc(input int idx, input logic lvl);
    if (idx < 3) gclk[idx] = lvl;
    else         ptClk = lvl;
  endtask

  task automatic pulseSrc(input int idx);
    setSrc(idx, 1'b1); waitCyc(1);
    setSrc(idx, 1'b0); waitCyc(1);
  endtask

  task automatic safeCfg(input logic [1:0] mode, input logic [1:0] sel, input logic inv);
    ptCe = 1'b0;
    cfgMode = mode; cfgClkSel = sel; cfgClkInv = inv;
    waitCyc(2);
    ptCe = 1'b1;
  endtask

  task automatic tResetState();
    rstN = 1'b0; initPulse = 0; gclk = '0; ptClk = 0; ptCe = 1; ptSet = 0;
    ptReset = 0; gsr = 0; sumTerm = 0; cfgMode = 2'b00; cfgClkSel = 2'd0; cfgClkInv = 0;
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(1);
    chk("R1 reset default", fbOut, 1'b0);
    chk("R1 reset user 1", fbOutHi, 1'b1);
    chk("R11 io mirrors fb", ioOut, fbOut);
    chk("R11 io mirrors fb hi", ioOutHi, fbOutHi);
  endtask

  task automatic tDMode();
    sumTerm = 1; waitCyc(1);
    chk("R2 no edge hold", fbOut, 1'b0);
    pulseSrc(0);
    chk("R2 load 1", fbOut, 1'b1);
    sumTerm = 0; pulseSrc(0);
    chk("R2 load 0", fbOut, 1'b0);
  endtask

  task automatic tSelect();
    safeCfg(2'b00, 2'd1, 1'b0);
    sumTerm = 1; pulseSrc(0);
    chk("R5 unselected gclk0", fbOut, 1'b0);
    pulseSrc(1);
    chk("R5 selected gclk1", fbOut, 1'b1);
    safeCfg(2'b00, 2'd3, 1'b0);
    sumTerm = 0; pulseSrc(2);
    chk("R5 unselected gclk2", fbOut, 1'b1);
    pulseSrc(3);
    chk("R5 product-term clock", fbOut, 1'b0);
  endtask

  task automatic tInvert();
    safeCfg(2'b00, 2'd2, 1'b1);
    sumTerm = 1;
    setSrc(2, 1'b1); waitCyc(1);
    chk("R6 rising ignored when inverted", fbOut, 1'b0);
    setSrc(2, 1'b0); waitCyc(1);
    chk("R6 falling loads when inverted", fbOut, 1'b1);
    safeCfg(2'b00, 2'd0, 1'b0);
  endtask

  task automatic tEnable();
    ptCe = 0; sumTerm = 0; pulseSrc(0);
    chk("R7 disabled holds", fbOut, 1'b1);
    ptCe = 1; pulseSrc(0);
    chk("R7 re-enabled loads", fbOut, 1'b0);
  endtask

  task automatic tToggle();
    safeCfg(2'b01, 2'd0, 1'b0);
    sumTerm = 1; pulseSrc(0);
    chk("R3 toggle to 1", fbOut, 1'b1);
    pulseSrc(0);
    chk("R3 toggle to 0", fbOut, 1'b0);
    sumTerm = 0; pulseSrc(0);
    chk("R3 hold on 0", fbOut, 1'b0);
    sumTerm = 1; pulseSrc(0);
    chk("R3 toggle again", fbOut, 1'b1);
    safeCfg(2'b00, 2'd0, 1'b0);
  endtask

  task automatic tForces();
    sumTerm = 1;
    ptReset = 1; #1;
    chk("R9 reset immediate", fbOut, 1'b0);
    waitCyc(1); ptReset = 0; waitCyc(1);
    chk("R9 reset retained", fbOut, 1'b0);
    ptSet = 1; #1;
    chk("R8 set immediate", fbOut, 1'b1);
    waitCyc(1); ptSet = 0; waitCyc(1);
    chk("R8 set retained", fbOut, 1'b1);
    ptSet = 1; ptReset = 1; #1;
    chk("R9 reset beats set", fbOut, 1'b0);
    gsr = 1; #1;
    chk("R10 gsr beats both", fbOut, 1'b0);
    chk("R10 gsr user 1", fbOutHi, 1'b1);
    waitCyc(1); ptSet = 0; ptReset = 0; waitCyc(1); gsr = 0; waitCyc(1);
    chk("R10 gsr retained user 1", fbOutHi, 1'b1);
  endtask

  task automatic tBypass();
    cfgMode = 2'b10; sumTerm = 1; #1;
    chk("R4 bypass follows 1", fbOut, 1'b1);
    sumTerm = 0; #1;
    chk("R4 bypass follows 0", fbOut, 1'b0);
    sumTerm = 1; ptReset = 1; #1;
    chk("R4 reset ignored in bypass", fbOut, 1'b1);
    waitCyc(1); ptReset = 0; sumTerm = 0; pulseSrc(0);
    chk("R4 clock ignored in bypass", fbOut, 1'b0);
    safeCfg(2'b00, 2'd0, 1'b0);
  endtask

  task automatic tInit();
    sumTerm = 1; pulseSrc(0);
    chk("R2 preset before init", fbOut, 1'b1);
    sumTerm = 0; pulseSrc(0);
    chk("R2 hi cell loads 0", fbOutHi, 1'b0);
    sumTerm = 1; pulseSrc(0);
    initPulse = 1; waitCyc(1); initPulse = 0;
    chk("R1 init loads default", fbOut, 1'b0);
    chk("R1 init loads user 1", fbOutHi, 1'b1);
  endtask

  initial begin
    tResetState();
    tDMode();
    tSelect();
    tInvert();
    tEnable();
    tToggle();
    tForces();
    tBypass();
    tInit();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule